// File: doc/BRIEF.md
# Two-Wire Register Access Master

This block is a two-wire (I2C-style) bus master for single-byte register transfers to one slave. A transfer is described by a 7-bit device address, a direction bit, an internal address length of zero to three bytes and a 24-bit internal address value. One pulse on `start_i` starts the whole sequence. The block generates the start, repeated start and stop conditions, shifts out the address bytes, samples each acknowledge and either sends one write byte or receives one read byte.

For a read that carries an internal address, the block first writes that address and then turns the bus round with a repeated start, sending the device address again with the read bit. With a length of zero the transfer is a plain device access. A slave whose address is wider than 7 bits is reached by putting its extra address bits in the internal address value and setting the length to match. Both bus lines are open-drain: the block only asserts pull-low enables and reads SDA back from the bus. The SCL timing comes from the system clock through a divider set at run time.

Top module: `twowire_reg_master`

## Requirements
- R1: A one-cycle `start_i` while `busy_o` is low raises `busy_o` on the next cycle. `busy_o` stays high until the stop condition has completed. A `start_i` pulse while `busy_o` is high is ignored and puts nothing on the bus.
- R2: While SCL stays released, SDA changes only inside a start, repeated start or stop condition, never inside a data or acknowledge bit. Bits are sent MSB first.
- R3: A write with internal address length N (1 to 3) puts this on the bus: start, then the byte {device address, 0}, then N internal address bytes (the byte holding bits [8N-1:8N-8] first, bits [7:0] last), then the write byte, then stop.
- R4: A write with length 0 puts this on the bus: start, then {device address, 0}, then the write byte, then stop.
- R5: A read with length N > 0 puts this on the bus: start, then {device address, 0}, then the N internal address bytes in the R3 order, then a repeated start, then {device address, 1}. It then receives one byte, answers it with a not-acknowledge (SDA high) and sends a stop.
- R6: A read with length 0 puts this on the bus: start, then {device address, 1}. It then receives one byte, answers it with a not-acknowledge and sends a stop.
- R7: If SDA is high in the acknowledge slot of any byte the slave receives, the block sends no further bytes and sends a stop. `nack_o` then goes high and stays high until the next accepted start.
- R8: `rdata_o` takes the received byte when a read completes without a NACK. It keeps that value through later writes and failed transfers.
- R9: Every SCL high period lasts 2*(`clk_div_i`+1) system clock cycles.
- R10: `done_o` is a one-cycle pulse. It comes in the cycle in which `busy_o` first reads low after a transfer, whether or not that transfer was acknowledged.
- R11: While `busy_o` is low, including after reset, both `scl_oe_o` and `sda_oe_o` are low, so both lines are released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that starts a transfer |
| dev_addr_i | input | 7 | Device address |
| rd_i | input | 1 | 1 = read, 0 = write |
| iadr_size_i | input | 2 | Number of internal address bytes, 0 to 3 |
| iadr_i | input | 24 | Internal address value |
| wdata_i | input | 8 | Byte to write |
| clk_div_i | input | 8 | Quarter-bit length minus one, in clock cycles |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| nack_o | output | 1 | Sticky not-acknowledge flag |
| rdata_o | output | 8 | Last byte read |
| scl_oe_o | output | 1 | Pull SCL low when high |
| sda_oe_o | output | 1 | Pull SDA low when high |
| sda_i | input | 1 | SDA level read back from the bus |

## Verification
A wrong sequencer state shows up on the bus within one byte time. It appears as a missing, extra or reordered byte, as a repeated start in the wrong place, or as a stop where the bench's slave model still expects data, and the event scoreboard rejects that event as soon as it is decoded. A wrong bit-engine phase or divider count shows up at the very next SCL falling edge as a wrong high-time. It also shows up as an SDA edge inside a bit, which the slave model decodes as a stray start or stop. Errors in the flag logic show up within a few cycles of the transfer's end, on `nack_o`, `done_o`, `busy_o` or `rdata_o`.

// File: rtl/tw_pkg.sv
package tw_pkg;

   // bus symbols executed by the bit engine, four quarter phases each
   typedef enum logic [1:0] {
      SYM_START   = 2'd0,
      SYM_RESTART = 2'd1,
      SYM_STOP    = 2'd2,
      SYM_BIT     = 2'd3
   } tw_sym_e;

   // transfer sequencer states
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_START  = 3'd1,
      ST_TX     = 3'd2,
      ST_RSTART = 3'd3,
      ST_RX     = 3'd4,
      ST_STOP   = 3'd5
   } tw_state_e;

   // role of the byte being shifted out
   typedef enum logic [1:0] {
      BK_DEV  = 2'd0,
      BK_IADR = 2'd1,
      BK_DEVR = 2'd2,
      BK_DATA = 2'd3
   } tw_byte_e;

endpackage

// File: rtl/tw_quarter_tick.sv
module tw_quarter_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);
   logic [DIV_W-1:0] cnt_q;

   assign tick_o = run_i && (cnt_q == div_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (!run_i || tick_o) cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/tw_bit_engine.sv
module tw_bit_engine
   import tw_pkg::*;
#(
   parameter int IN_SYNC = 2
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    cmd_valid_i,
   input  tw_sym_e cmd_sym_i,
   input  logic    cmd_bit_i,
   input  logic    tick_i,
   input  logic    sda_i,
   output logic    active_o,
   output logic    done_o,
   output logic    rx_o,
   output logic    scl_oe_o,
   output logic    sda_oe_o
);
   tw_sym_e    sym_q;
   logic [1:0] phase_q;
   logic       bit_q, active_q, rx_q, sda_s;

   if (IN_SYNC == 0) begin : g_nosync
      assign sda_s = sda_i;
   end else begin : g_sync
      logic [IN_SYNC-1:0] pipe_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe_q <= '1;
         else        pipe_q <= IN_SYNC'({pipe_q, sda_i});
      end
      assign sda_s = pipe_q[IN_SYNC-1];
   end

   assign active_o = active_q;
   assign rx_o     = rx_q;
   assign done_o   = active_q && tick_i && (phase_q == 2'd3);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sym_q    <= SYM_STOP;
         phase_q  <= 2'd3;
         bit_q    <= 1'b1;
         active_q <= 1'b0;
         rx_q     <= 1'b1;
      end else if (!active_q) begin
         if (cmd_valid_i) begin
            sym_q    <= cmd_sym_i;
            bit_q    <= cmd_bit_i;
            phase_q  <= 2'd0;
            active_q <= 1'b1;
         end
      end else if (tick_i) begin
         if (phase_q == 2'd2) rx_q <= sda_s;
         if (phase_q == 2'd3) active_q <= 1'b0;
         else                 phase_q  <= phase_q + 1'b1;
      end
   end

   // pull-low enables decoded from symbol and phase; idle holds phase 3
   always_comb begin
      scl_oe_o = 1'b0;
      sda_oe_o = 1'b0;
      unique case (sym_q)
         SYM_START: begin
            scl_oe_o = (phase_q == 2'd3);
            sda_oe_o = phase_q[1];
         end
         SYM_RESTART: begin
            scl_oe_o = (phase_q == 2'd0) || (phase_q == 2'd3);
            sda_oe_o = phase_q[1];
         end
         SYM_STOP: begin
            scl_oe_o = (phase_q == 2'd0);
            sda_oe_o = !phase_q[1];
         end
         SYM_BIT: begin
            scl_oe_o = (phase_q == 2'd0) || (phase_q == 2'd3);
            sda_oe_o = !bit_q;
         end
      endcase
   end

   // R2: an SDA edge under a released SCL belongs to a bus condition
   assert_sda_edge_only_in_condition_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_oe_o && $past(!scl_oe_o) && !$stable(sda_oe_o)) |-> (sym_q != SYM_BIT));

   // R9: phases advance only on a divider tick
   assert_phase_waits_for_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && !tick_i) |=> $stable(phase_q));
endmodule

// File: rtl/twowire_reg_master.sv
module twowire_reg_master
   import tw_pkg::*;
#(
   parameter int DIV_W    = 8,
   parameter int IA_BYTES = 3,
   parameter int IN_SYNC  = 2,
   localparam int IA_W    = 8 * IA_BYTES,
   localparam int SZ_W    = $clog2(IA_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [6:0]       dev_addr_i,
   input  logic             rd_i,
   input  logic [SZ_W-1:0]  iadr_size_i,
   input  logic [IA_W-1:0]  iadr_i,
   input  logic [7:0]       wdata_i,
   input  logic [DIV_W-1:0] clk_div_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             nack_o,
   output logic [7:0]       rdata_o,
   output logic             scl_oe_o,
   output logic             sda_oe_o,
   input  logic             sda_i
);
   if (IA_BYTES < 1 || IA_BYTES > 4) begin : g_bad_ia
      $error("IA_BYTES must lie between 1 and 4");
   end
   if (IN_SYNC < 0 || IN_SYNC > 3) begin : g_bad_sync
      $error("IN_SYNC must lie between 0 and 3");
   end
   if (DIV_W < 2) begin : g_bad_div
      $error("DIV_W must be at least 2");
   end

   tw_state_e       st_q;
   tw_byte_e        kind_q;
   logic [7:0]      sh_q, rdata_q;
   logic [3:0]      bitcnt_q;
   logic [SZ_W-1:0] remain_q;
   logic [6:0]      dev_q;
   logic            rd_q, wait_q, nack_q, done_q;
   logic [IA_W-1:0] iadr_q, iadr_shift;
   logic [7:0]      wdata_q;
   logic [DIV_W-1:0] div_q;

   logic    cmd_valid, cmd_bit, eng_active, eng_done, eng_rx, tick;
   tw_sym_e cmd_sym;

   assign busy_o  = (st_q != ST_IDLE);
   assign done_o  = done_q;
   assign nack_o  = nack_q;
   assign rdata_o = rdata_q;

   assign iadr_shift = iadr_q >> {remain_q - 1'b1, 3'b000};

   // one symbol request per step; the engine is always idle when !wait_q
   assign cmd_valid = busy_o && !wait_q;
   always_comb begin
      cmd_bit = 1'b1;
      unique case (st_q)
         ST_START:  cmd_sym = SYM_START;
         ST_RSTART: cmd_sym = SYM_RESTART;
         ST_STOP:   cmd_sym = SYM_STOP;
         default: begin
            cmd_sym = SYM_BIT;
            if (st_q == ST_TX && !bitcnt_q[3]) cmd_bit = sh_q[7];
         end
      endcase
   end

   tw_quarter_tick #(.DIV_W(DIV_W)) i_tick (
      .clk(clk), .rst_n(rst_n), .run_i(eng_active), .div_i(div_q), .tick_o(tick)
   );

   tw_bit_engine #(.IN_SYNC(IN_SYNC)) i_engine (
      .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_sym_i(cmd_sym),
      .cmd_bit_i(cmd_bit), .tick_i(tick), .sda_i(sda_i), .active_o(eng_active),
      .done_o(eng_done), .rx_o(eng_rx), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         kind_q   <= BK_DEV;
         sh_q     <= '0;
         rdata_q  <= '0;
         bitcnt_q <= '0;
         remain_q <= '0;
         dev_q    <= '0;
         rd_q     <= 1'b0;
         iadr_q   <= '0;
         wdata_q  <= '0;
         div_q    <= '0;
         wait_q   <= 1'b0;
         nack_q   <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (cmd_valid) wait_q <= 1'b1;
         if (eng_done)  wait_q <= 1'b0;
         if (st_q == ST_IDLE) begin
            if (start_i) begin
               st_q     <= ST_START;
               dev_q    <= dev_addr_i;
               rd_q     <= rd_i;
               remain_q <= iadr_size_i;
               iadr_q   <= iadr_i;
               wdata_q  <= wdata_i;
               div_q    <= clk_div_i;
               nack_q   <= 1'b0;
            end
         end else if (eng_done) begin
            unique case (st_q)
               ST_START: begin
                  sh_q     <= {dev_q, rd_q && (remain_q == '0)};
                  kind_q   <= BK_DEV;
                  bitcnt_q <= '0;
                  st_q     <= ST_TX;
               end
               ST_RSTART: begin
                  sh_q     <= {dev_q, 1'b1};
                  kind_q   <= BK_DEVR;
                  bitcnt_q <= '0;
                  st_q     <= ST_TX;
               end
               ST_TX: begin
                  if (!bitcnt_q[3]) begin
                     sh_q     <= {sh_q[6:0], 1'b0};
                     bitcnt_q <= bitcnt_q + 1'b1;
                  end else begin
                     bitcnt_q <= '0;
                     if (eng_rx) begin
                        nack_q <= 1'b1;
                        st_q   <= ST_STOP;
                     end else if ((kind_q == BK_DEV || kind_q == BK_IADR) && remain_q != '0) begin
                        sh_q     <= iadr_shift[7:0];
                        remain_q <= remain_q - 1'b1;
                        kind_q   <= BK_IADR;
                     end else if (kind_q == BK_DATA) begin
                        st_q <= ST_STOP;
                     end else if (kind_q == BK_DEVR || (kind_q == BK_DEV && rd_q)) begin
                        st_q <= ST_RX;
                     end else if (rd_q) begin
                        st_q <= ST_RSTART;
                     end else begin
                        sh_q   <= wdata_q;
                        kind_q <= BK_DATA;
                     end
                  end
               end
               ST_RX: begin
                  if (!bitcnt_q[3]) begin
                     sh_q     <= {sh_q[6:0], eng_rx};
                     bitcnt_q <= bitcnt_q + 1'b1;
                  end else begin
                     rdata_q <= sh_q;
                     st_q    <= ST_STOP;
                  end
               end
               ST_STOP: begin
                  st_q   <= ST_IDLE;
                  done_q <= 1'b1;
               end
               default: st_q <= ST_IDLE;
            endcase
         end
      end
   end

   // R1: an accepted start makes the block busy on the next cycle
   assert_start_sets_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

   // R7: the NACK flag holds until a new transfer is accepted
   assert_nack_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (nack_o && !(start_i && !busy_o)) |=> nack_o);

   // R10: completion pulse coincides with the end of busy
   assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));
   assert_busy_falls_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   // R11: an idle master leaves both lines released
   assert_idle_lines_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!scl_oe_o && !sda_oe_o));
endmodule

// File: tb/test_twowire_reg_master.sv
`timescale 1ns/1ps
module test_twowire_reg_master;
   localparam int EV_S = 256, EV_SR = 257, EV_P = 258, EV_MNACK = 259, EV_MACK = 260;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst_n, start, rd, busy, done, nack, scl_oe, sda_oe;
   logic [6:0]  dev;
   logic [1:0]  isz;
   logic [23:0] iadr;
   logic [7:0]  wdata, rdata, div;
   logic        sl_oe = 1'b0;

   wire scl_w = ~scl_oe;
   wire sda_w = ~(sda_oe | sl_oe);

   twowire_reg_master i_twowire_reg_master (
      .clk(clk), .rst_n(rst_n), .start_i(start), .dev_addr_i(dev), .rd_i(rd),
      .iadr_size_i(isz), .iadr_i(iadr), .wdata_i(wdata), .clk_div_i(div),
      .busy_o(busy), .done_o(done), .nack_o(nack), .rdata_o(rdata),
      .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .sda_i(sda_w)
   );

   int n_tests = 0, n_fail = 0;
   bit finished = 0;
   int exp_q[$];
   int req_q[$];

   task automatic check(input bit ok, input int req, input string what, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // ---------------- slave model and scoreboard monitor ----------------
   int        cfg_nack_at = -1;
   int        cfg_div = 0;
   logic [7:0] cfg_rdval = 8'h00;
   longint    cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic   p_scl = 1'b1, p_sda = 1'b1;
   int     bitn = 0, byte_no = 0;
   logic [7:0] ssh = 8'h00;
   bit     in_txn = 0, in_read = 0, first_byte = 0, rd_addr = 0;
   longint rise_t = -1;

   task automatic emit(input int ev);
      int e, r;
      if (exp_q.size() == 0) begin
         check(1'b0, 3, "unexpected bus event", ev, -1);
      end else begin
         e = exp_q.pop_front();
         r = req_q.pop_front();
         check(ev == e, r, "bus event", ev, e);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (p_scl && scl_w && p_sda && !sda_w) begin
            check(bitn <= 1, 2, "start inside a byte", bitn, 0);   // R2
            emit(in_txn ? EV_SR : EV_S);
            if (!in_txn) byte_no = 0;
            in_txn = 1; in_read = 0; first_byte = 1; rd_addr = 0; bitn = 0; rise_t = -1;
            sl_oe <= 1'b0;
         end else if (p_scl && scl_w && !p_sda && sda_w) begin
            check(bitn <= 1, 2, "stop inside a byte", bitn, 0);    // R2
            emit(EV_P);
            in_txn = 0; in_read = 0; bitn = 0; rise_t = -1;
            sl_oe <= 1'b0;
         end else if (!p_scl && scl_w) begin
            rise_t = cyc;
            if (bitn < 8) ssh = {ssh[6:0], sda_w};
            else if (bitn == 8 && in_read) emit(sda_w ? EV_MNACK : EV_MACK);
            bitn++;
         end else if (p_scl && !scl_w) begin
            if (rise_t >= 0)   // R9: SCL high time
               check(int'(cyc - rise_t) == 2 * (cfg_div + 1), 9, "SCL high cycles",
                     int'(cyc - rise_t), 2 * (cfg_div + 1));
            rise_t = -1;
            if (bitn == 8) begin
               if (!in_read) begin
                  emit(int'(ssh));
                  sl_oe <= (byte_no != cfg_nack_at);
                  rd_addr = first_byte && ssh[0] && (byte_no != cfg_nack_at);
                  first_byte = 0;
                  byte_no++;
               end else sl_oe <= 1'b0;
            end else if (bitn == 9) begin
               sl_oe <= 1'b0;
               if (rd_addr) begin
                  in_read = 1; rd_addr = 0;
                  sl_oe <= ~cfg_rdval[7];
               end
               bitn = 0;
            end else if (in_read && bitn >= 1 && bitn <= 7) begin
               sl_oe <= ~cfg_rdval[7 - bitn];
            end
         end
      end
      p_scl = scl_w;
      p_sda = sda_w;
   end

   // ---------------- driver ----------------
   task automatic push(input int ev, input int req);
      exp_q.push_back(ev);
      req_q.push_back(req);
   endtask

   task automatic run_xfer(input logic [6:0] d, input bit r, input int sz, input logic [23:0] ia,
                           input logic [7:0] wd, input int dv, input int nack_at,
                           input logic [7:0] rdv, input int req, input bit poke);
      int seq[$];
      int idx = 0;
      bit stopped = 0;
      int t = 0;
      cfg_nack_at = nack_at; cfg_div = dv; cfg_rdval = rdv;
      push(EV_S, req);
      seq.push_back((r && sz == 0) ? {d, 1'b1} : {d, 1'b0});
      for (int k = sz; k >= 1; k--) seq.push_back(int'(ia[8*k-1 -: 8]));
      if (r && sz > 0) begin
         seq.push_back(EV_SR);
         seq.push_back({d, 1'b1});
      end
      if (!r) seq.push_back(int'(wd));
      foreach (seq[i]) begin
         if (!stopped) begin
            push(seq[i], req);
            if (seq[i] < 256) begin
               if (idx == nack_at) begin
                  push(EV_P, 7);   // R7: stop right after a refused byte
                  stopped = 1;
               end
               idx++;
            end
         end
      end
      if (!stopped) begin
         if (r) push(EV_MNACK, req);
         push(EV_P, req);
      end
      @(negedge clk);
      dev = d; rd = r; isz = 2'(sz); iadr = ia; wdata = wd; div = 8'(dv); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, 1, "busy after start", busy, 1);
      if (poke) begin   // R1: start while busy is ignored
         repeat (20) @(negedge clk);
         dev = ~d; rd = ~r; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (!done && t < 20000) begin
         @(negedge clk);
         t++;
      end
      check(done == 1'b1, 10, "done seen", done, 1);
      check(busy == 1'b0, 10, "busy low with done", busy, 0);
      check(nack == stopped, 7, "nack flag", nack, stopped);
      @(negedge clk);
      check(done == 1'b0, 10, "done width", done, 0);
      check(!scl_oe && !sda_oe, 11, "lines released", {scl_oe, sda_oe}, 0);
      repeat (10) @(negedge clk);
      check(exp_q.size() == 0, req, "events outstanding", exp_q.size(), 0);
      exp_q.delete();
      req_q.delete();
      if (r && !stopped) check(rdata == rdv, 8, "read data", rdata, rdv);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_tests++; n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; dev = '0; rd = 1'b0; isz = '0; iadr = '0; wdata = '0; div = 8'd3;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 / R1 / R7: reset state
      check(busy == 1'b0, 1, "reset busy", busy, 0);
      check(done == 1'b0, 10, "reset done", done, 0);
      check(nack == 1'b0, 7, "reset nack", nack, 0);
      check(!scl_oe && !sda_oe, 11, "reset lines", {scl_oe, sda_oe}, 0);

      run_xfer(7'h2C, 0, 0, 24'h0, 8'h96, 3, -1, 8'h00, 4, 0);        // R4
      run_xfer(7'h50, 0, 1, 24'h00007E, 8'h01, 2, -1, 8'h00, 3, 0);    // R3
      run_xfer(7'h11, 0, 3, 24'hA1B2C3, 8'h3C, 4, -1, 8'h00, 3, 1);    // R3 + R1 ignore
      run_xfer(7'h68, 1, 2, 24'h001234, 8'h00, 3, -1, 8'h5A, 5, 0);    // R5
      run_xfer(7'h3B, 1, 0, 24'h0, 8'h00, 2, -1, 8'hC3, 6, 0);         // R6
      run_xfer(7'h22, 0, 2, 24'h00BEEF, 8'h77, 2, -1, 8'h00, 3, 0);
      check(rdata == 8'hC3, 8, "read data held over a write", rdata, 8'hC3);   // R8
      run_xfer(7'h45, 0, 2, 24'h000102, 8'h99, 2, 0, 8'h00, 7, 0);     // R7 refused at device byte
      repeat (50) @(negedge clk);
      check(nack == 1'b1, 7, "nack still set while idle", nack, 1);
      check(rdata == 8'hC3, 8, "read data held over a nack", rdata, 8'hC3);   // R8
      run_xfer(7'h71, 1, 3, 24'h0A0B0C, 8'h00, 3, 2, 8'hEE, 7, 0);     // R7 refused mid-address
      run_xfer(7'h0F, 1, 1, 24'h000044, 8'h00, 2, -1, 8'h00, 5, 0);    // R7 cleared, R5
      run_xfer(7'h7E, 1, 3, 24'h3FFFFF, 8'h00, 5, -1, 8'hFF, 5, 0);    // R5 wide address

      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule